// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End

This block is the bus-facing half of a two-wire serial slave. It watches an open-drain clock line and data line, sampled by a much faster system clock. It finds start and stop conditions and shifts in an address byte. It acknowledges only when the address carries the fixed device-type nibble and the four strapped address bits. The bytes that follow are handed to a command layer one at a time. When the command layer asks for it, the block shifts bytes out to the master.

The address byte carries no direction bit. The upper nibble is the constant type code `0101` and the lower nibble must equal `dev_addr_i`. While a nonvolatile write is busy (`busy_i` high), the block withholds the address acknowledge. A master can therefore repeat start-plus-address until it gets an acknowledge, which tells it the write has finished.

Top module: `twowire_slave_fe`

## Requirements
- R1: After reset the data line is released (`sda_pull_o` = 0) and `rx_valid_o` and `tx_load_o` are low.
- R2: Clock pulses that arrive before any start condition are ignored. No acknowledge is driven and no byte is delivered.
- R3: After a start, the first 8 bits are taken MSB first as an address. When bits [7:4] equal `0101` and bits [3:0] equal `dev_addr_i`, the block pulls the data line low through the ninth clock.
- R4: On an address mismatch the line stays released and no byte is delivered until the next start condition.
- R5: If `busy_i` is high when the eighth address bit completes, the address is not acknowledged. When busy is low, the same address is acknowledged.
- R6: Each byte received after an acknowledged address is presented on `rx_data_o` (MSB first on the wire) with a one-cycle `rx_valid_o` pulse and is acknowledged in its ninth clock. `rx_cmd_o` is 1 only for the first byte after the address.
- R7: If `tx_mode_i` is high when the acknowledge clock of a received byte ends, the block loads `tx_data_i` (pulsing `tx_load_o`) and drives it MSB first. A bit value of 0 is driven as `sda_pull_o` = 1 and a bit value of 1 as a released line.
- R8: After a transmitted byte, a master acknowledge with `tx_mode_i` high loads and sends the next byte. A master not-acknowledge leaves the line released until the next start condition.
- R9: A stop, or a repeated start, at any point ends the current transfer. The line is released and the next byte after a start is treated as an address again.
- R10: `sda_pull_o` only changes while the synchronized clock line is low, so the block never creates a start or stop itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| dev_addr_i | input | 4 | Strapped device address bits |
| busy_i | input | 1 | Nonvolatile write in progress; suppresses address acknowledge |
| tx_mode_i | input | 1 | Command layer requests that the next byte be transmitted |
| tx_data_i | input | 8 | Byte to transmit when loaded |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| rx_valid_o | output | 1 | One-cycle pulse: received byte on `rx_data_o` |
| rx_data_o | output | 8 | Last received byte |
| rx_cmd_o | output | 1 | Received byte is the first one after the address |
| tx_load_o | output | 1 | One-cycle pulse: `tx_data_i` was taken for sending |

## Verification
The hardest case to reach is a transfer cut short in the middle of a byte. A stop or repeated start then lands while the bit counter and shift register hold partial state, and the next byte must still be decoded cleanly as an address. Directed sequences send four data bits and then a stop, or send a repeated start in the middle of a byte. Each is followed at once by a fresh address that must be acknowledged, with no stray byte delivered. The busy-polling case comes next in difficulty. The bench repeats the same address with `busy_i` set and then cleared. The random loop also mixes busy, address mismatches and payload lengths.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_TACK,
    ST_SKIP
  } tws_state_e;
endpackage

// File: rtl/tws_sync_bit.sv
module tws_sync_bit #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic cur_o,
  output logic prev_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {(STAGES+1){RESET_VAL}};
    else         chain_q <= {chain_q[STAGES-1:0], d_i};
  end

  assign cur_o  = chain_q[STAGES-1];
  assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/tws_line_cond.sv
module tws_line_cond #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] line_in, line_cur, line_prev;
  assign line_in = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    tws_sync_bit #(.STAGES(STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (line_in[g]),
      .cur_o  (line_cur[g]),
      .prev_o (line_prev[g])
    );
  end

  assign scl_s_o    = line_cur[1];
  assign sda_s_o    = line_cur[0];
  assign scl_rise_o = line_cur[1] & ~line_prev[1];
  assign scl_fall_o = ~line_cur[1] & line_prev[1];
  // data edge while clock held high on both samples
  assign start_o    = line_cur[1] & line_prev[1] & line_prev[0] & ~line_cur[0];
  assign stop_o     = line_cur[1] & line_prev[1] & ~line_prev[0] & line_cur[0];
endmodule

// File: rtl/twowire_slave_fe.sv
module twowire_slave_fe
  import tws_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         BYTE_W      = 8,
  parameter int         TYPE_W      = 4,
  parameter int         ADDR_W      = 4,
  parameter logic [3:0] DEV_TYPE    = 4'b0101
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              busy_i,
  input  logic              tx_mode_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              sda_pull_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_cmd_o,
  output logic              tx_load_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;

  tws_line_cond #(.STAGES(SYNC_STAGES)) u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_s_o    (scl_s),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_p),
    .stop_o     (stop_p)
  );

  tws_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              pull_q, first_q, mack_q;
  logic              rx_valid_q, rx_cmd_q, tx_load_q;
  logic [BYTE_W-1:0] rx_data_q;
  logic              addr_hit;

  assign addr_hit = (shreg_q[BYTE_W-1 -: TYPE_W] == DEV_TYPE) &&
                    (shreg_q[ADDR_W-1:0] == dev_addr_i) && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      shreg_q    <= '0;
      pull_q     <= 1'b0;
      first_q    <= 1'b0;
      mack_q     <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
      rx_cmd_q   <= 1'b0;
      tx_load_q  <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      tx_load_q  <= 1'b0;
      if (stop_p) begin
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
      end else if (start_p) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        pull_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_RX: begin
            if (scl_rise && cnt_q != CNT_FULL) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
              cnt_q   <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == CNT_FULL) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (addr_hit) begin
                  state_q <= ST_AACK;
                  pull_q  <= 1'b1;
                  first_q <= 1'b1;
                end else begin
                  state_q <= ST_SKIP;
                end
              end else begin
                state_q    <= ST_RACK;
                pull_q     <= 1'b1;
                rx_valid_q <= 1'b1;
                rx_data_q  <= shreg_q;
                rx_cmd_q   <= first_q;
                first_q    <= 1'b0;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              pull_q  <= 1'b0;
              state_q <= ST_RX;
            end
          end
          ST_RACK, ST_TACK: begin
            if (scl_rise && state_q == ST_TACK) mack_q <= ~sda_s;
            if (scl_fall) begin
              if (tx_mode_i && (state_q == ST_RACK || mack_q)) begin
                shreg_q   <= tx_data_i;
                pull_q    <= ~tx_data_i[BYTE_W-1];
                tx_load_q <= 1'b1;
                cnt_q     <= '0;
                state_q   <= ST_TX;
              end else begin
                pull_q  <= 1'b0;
                cnt_q   <= '0;
                state_q <= (state_q == ST_TACK && !mack_q) ? ST_SKIP : ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt_q == CNT_LAST) begin
                pull_q  <= 1'b0;
                cnt_q   <= '0;
                mack_q  <= 1'b0;
                state_q <= ST_TACK;
              end else begin
                cnt_q   <= cnt_q + 1'b1;
                shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                pull_q  <= ~shreg_q[BYTE_W-2];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_data_q;
  assign rx_cmd_o   = rx_cmd_q;
  assign tx_load_o  = tx_load_q;
endmodule

// File: rtl/twowire_slave_fe_chk.sv
module twowire_slave_fe_chk
  import tws_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s_i,
  input logic       stop_i,
  input logic       busy_i,
  input logic [3:0] dev_addr_i,
  input logic [7:0] tx_data_i,
  input logic [7:0] shreg_i,
  input tws_state_e state_i,
  input logic       sda_pull_o,
  input logic       rx_valid_o,
  input logic       tx_load_o
);
  assert_addr_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_AACK && $past(state_i) == ST_ADDR) |->
      ($past(shreg_i) == {4'b0101, $past(dev_addr_i)}));

  assert_busy_nack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_AACK && $past(state_i) == ST_ADDR) |-> !$past(busy_i));

  assert_rx_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> sda_pull_o);

  assert_tx_msb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |-> (sda_pull_o == !$past(tx_data_i[7])));

  assert_stop_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!sda_pull_o && state_i == ST_IDLE));

  assert_pull_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull_o) |-> !scl_s_i);
endmodule

bind twowire_slave_fe twowire_slave_fe_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s_i    (scl_s),
  .stop_i     (stop_p),
  .busy_i     (busy_i),
  .dev_addr_i (dev_addr_i),
  .tx_data_i  (tx_data_i),
  .shreg_i    (shreg_q),
  .state_i    (state_q),
  .sda_pull_o (sda_pull_o),
  .rx_valid_o (rx_valid_o),
  .tx_load_o  (tx_load_o)
);

// File: tb/twowire_slave_fe_test.sv
module twowire_slave_fe_test;
  localparam int Q = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [3:0] dev_addr = 4'h3;
  logic       busy = 1'b0, tx_mode = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       pull, rx_valid, rx_cmd, tx_load;
  logic [7:0] rx_data;
  wire        sda_line = sda_m & ~pull;

  int checks = 0, fails = 0, rx_n = 0, load_n = 0;
  logic [8:0] rx_log [0:255];
  bit done = 0;

  always #2.5 clk = ~clk;

  twowire_slave_fe uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .dev_addr_i(dev_addr), .busy_i(busy), .tx_mode_i(tx_mode),
    .tx_data_i(tx_data), .sda_pull_o(pull), .rx_valid_o(rx_valid),
    .rx_data_o(rx_data), .rx_cmd_o(rx_cmd), .tx_load_o(tx_load)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_log[rx_n[7:0]] = {rx_cmd, rx_data};
      rx_n++;
    end
    if (tx_load) load_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_ack(input logic [7:0] a, input logic [3:0] d, input bit b);
    return (a[7:4] == 4'b0101) && (a[3:0] == d) && !b;
  endfunction

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input bit b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] v, output bit acked);
    bit l;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(l);
    acked = !l;
  endtask

  task automatic get_byte(output logic [7:0] v, input bit give_ack);
    bit l;
    for (int i = 7; i >= 0; i--) begin get_bit(l); v[i] = l; end
    put_bit(!give_ack);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a;
    int base;
    logic [7:0] v;
    void'($urandom(32'd11));
    repeat (4) @(negedge clk);
    chk(pull == 0 && rx_valid == 0 && tx_load == 0, "R1 reset", {pull, rx_valid, tx_load}, 0);
    rst_n = 1'b1;
    wq();

    // R2: full address byte clocked with no start
    scl_m = 1'b0; wq();
    put_byte(8'h53, a);
    chk(a == 0, "R2 no ack before start", a, 0);
    put_byte(8'hA5, a);
    chk(a == 0 && rx_n == 0, "R2 no byte before start", rx_n, 0);

    // R3 / R6: match, command and data byte
    bus_start();
    put_byte(8'h53, a); chk(a == 1, "R3 address ack", a, 1);
    put_byte(8'h9C, a); chk(a == 1, "R6 cmd ack", a, 1);
    put_byte(8'h2D, a); chk(a == 1, "R6 data ack", a, 1);
    bus_stop();
    chk(rx_n == 2 && rx_log[0] == {1'b1, 8'h9C}, "R6 cmd byte", rx_log[0], {1'b1, 8'h9C});
    chk(rx_log[1] == {1'b0, 8'h2D}, "R6 data byte", rx_log[1], {1'b0, 8'h2D});

    // R4: wrong type nibble, then data
    base = rx_n;
    bus_start();
    put_byte(8'h73, a); chk(a == 0, "R4 mismatch nack", a, 0);
    put_byte(8'h11, a); chk(a == 0 && rx_n == base, "R4 idle after mismatch", rx_n, base);
    bus_stop();

    // R5: busy polling
    busy = 1'b1;
    bus_start(); put_byte(8'h53, a); chk(a == 0, "R5 busy nack", a, 0); bus_stop();
    busy = 1'b0;
    bus_start(); put_byte(8'h53, a); chk(a == 1, "R5 ack after busy", a, 1); bus_stop();

    // R7 / R8: read two bytes, then nack
    load_n = 0;
    tx_mode = 1'b1; tx_data = 8'hB4;
    bus_start(); put_byte(8'h53, a);
    put_byte(8'h90, a);
    tx_data = 8'h6A;
    begin
      bit l;
      for (int i = 7; i >= 0; i--) begin get_bit(l); v[i] = l; end
      chk(v == 8'hB4, "R7 first tx byte", v, 8'hB4);
      tx_data = 8'h6A;
      put_bit(1'b0);
    end
    get_byte(v, 1'b0);
    chk(v == 8'h6A, "R8 second tx byte after master ack", v, 8'h6A);
    chk(load_n == 2, "R7 load pulses", load_n, 2);
    get_byte(v, 1'b0);
    chk(v == 8'hFF && load_n == 2, "R8 released after nack", v, 8'hFF);
    tx_mode = 1'b0;
    bus_stop();

    // R9: stop in mid byte
    base = rx_n;
    bus_start(); put_byte(8'h53, a);
    for (int i = 0; i < 4; i++) put_bit(i[0]);
    bus_stop();
    bus_start(); put_byte(8'h53, a);
    chk(a == 1 && rx_n == base, "R9 address after mid-byte stop", rx_n, base);
    // repeated start mid byte
    for (int i = 0; i < 5; i++) put_bit(1'b1);
    bus_start(); put_byte(8'h53, a);
    chk(a == 1 && rx_n == base, "R9 address after repeated start", rx_n, base);
    put_byte(8'h42, a);
    bus_stop();
    chk(rx_n == base + 1 && rx_log[base[7:0]] == {1'b1, 8'h42}, "R9 cmd after restart",
        rx_log[base[7:0]], {1'b1, 8'h42});

    // random mix
    for (int t = 0; t < 36; t++) begin
      logic [7:0] ad;
      int n;
      bit e;
      logic [7:0] pay [0:3];
      dev_addr = 4'($urandom);
      busy = ($urandom % 4) == 0;
      ad = ($urandom % 2) ? {4'b0101, dev_addr} : 8'($urandom);
      n = $urandom % 4;
      e = exp_ack(ad, dev_addr, busy);
      base = rx_n;
      bus_start();
      put_byte(ad, a);
      chk(a == e, "R3 R4 R5 random address", a, e);
      for (int k = 0; k < n; k++) begin
        pay[k] = 8'($urandom);
        put_byte(pay[k], a);
        chk(a == e, "R6 random byte ack", a, e);
      end
      bus_stop();
      chk(rx_n == base + (e ? n : 0), "R6 random byte count", rx_n - base, e ? n : 0);
      if (e)
        for (int k = 0; k < n; k++)
          chk(rx_log[8'(base + k)] == {k == 0, pay[k]}, "R6 random byte data",
              rx_log[8'(base + k)], {k == 0, pay[k]});
    end

    chk(pull == 0, "R9 idle release", pull, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule